// File: doc/BRIEF.md
# Offset-Injecting Loop Integrator and Pulse Driver

This block forms the digital back end of a frequency-locked loop. A phase-movement detector reports small signed counts, one unit being a fixed fraction of an output cycle, and the block keeps their running total in a saturating signed integrator. At a selectable interval of update periods it also adds a single +1 or -1 into that total. With the loop closed, the feedback then has to slip the output phase by one unit per interval, which moves the output frequency by a very small, exactly known amount.

Time is cut into update periods of a fixed number of fast clock cycles. At the last cycle of each period the integrator value is captured. During the whole following period a fixed-magnitude drive pulse is issued whose length in fast cycles is the captured magnitude times a programmable width-per-unit count, capped at one full period. A separate sign output tells the external charge-pump filter which way to push. A zero capture issues no pulse and leaves the sign unchanged. While the loop enable is low, the integrator and the interval counter are held at zero and no pulse is issued.

Top module: `loop_integ_driver`

## Requirements
- R1: After reset the integrator reads 0, `pulseActive` is 0 and `pulseNeg` is 0.
- R2: In each cycle where `detValid` is 1, the two's-complement value on `detVal` is added to the integrator. When `detValid` is 0, `detVal` has no effect.
- R3: The integrator saturates at its signed limits (-128 and +127 for the default width) instead of wrapping.
- R4: When `offInterval` is nonzero, one unit is added on the closing cycle of every `offInterval`-th update period: +1 when `offNeg` is 0 and -1 when it is 1. Zero disables injection, and an interval of 256 periods works.
- R5: On the last cycle of each update period the integrator value, including that cycle's additions, is captured. The resulting pulse begins in the first cycle of the next period, which gives one period of delay.
- R6: The pulse stays high for |capture| × `unitWidth` fast cycles, capped at `UPD_CYC` cycles. At the cap it is high for the whole period.
- R7: `pulseNeg` is 1 when the capture is negative and 0 when it is positive. A zero capture gives no pulse and leaves `pulseNeg` at its previous value.
- R8: While `loopEn` is 0, the integrator, the interval counter and the period phase are held at zero and `pulseActive` stays 0, whatever arrives on `detValid`. `pulseNeg` keeps its value.
- R9: When a detector answers each pulse with one unit of the opposite sign, every injected offset is cancelled and the integrator is back at zero one period after the injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Active-low synchronous reset |
| loopEn | input | 1 | Loop enable; low clears and holds the loop |
| detValid | input | 1 | Detector count is valid this cycle |
| detVal | input | DET_W | Signed detector count |
| offNeg | input | 1 | Offset sign: 0 adds +1, 1 adds -1 |
| offInterval | input | INTV_W | Update periods between offsets; 0 = none |
| unitWidth | input | WPU_W | Fast cycles of pulse per integrator unit |
| pulseActive | output | 1 | Drive pulse is on |
| pulseNeg | output | 1 | Drive polarity: 1 = negative |
| integOut | output | ACC_W | Signed integrator value |

## Verification
A vector table feeds one detector count per period with mixed signs, an invalid strobe, a zero crossing and an overdrive. This separates correct accumulation, the one-period pulse delay, the width scaling with its cap, and the sign hold on a zero capture. Directed runs push counts every cycle into both rails, run open-loop with positive, negative and 256-period offsets to tell the injection cadence and polarity apart, and close the loop by answering each pulse with an opposing count. A run with the enable low and detector strobes present shows that nothing reaches the integrator or the pulse.

// File: rtl/loop_integ_pkg.sv
package loop_integ_pkg;

  // Strobes handed from control to datapath each fast cycle
  typedef struct packed {
    logic tick;    // last cycle of an update period
    logic inject;  // add the unit offset on this cycle
    logic injNeg;  // offset polarity: 1 means -1
    logic clear;   // loop disabled: hold state at zero
  } ctrl_stb_t;

endpackage

// File: rtl/loop_integ_ctrl.sv
module loop_integ_ctrl
  import loop_integ_pkg::*;
#(
  parameter int UPD_CYC = 16,
  parameter int INTV_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loopEn,
  input  logic              offNeg,
  input  logic [INTV_W-1:0] offInterval,
  output ctrl_stb_t         stb
);

  localparam int PH_W = (UPD_CYC > 2) ? $clog2(UPD_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(UPD_CYC - 1);

  logic [PH_W-1:0]   phaseCnt;
  logic [INTV_W-1:0] intvCnt;
  logic              intvDue;

  always_comb begin
    intvDue    = (offInterval != '0) && (intvCnt >= offInterval - INTV_W'(1));
    stb.clear  = !loopEn;
    stb.tick   = loopEn && (phaseCnt == PH_LAST);
    stb.inject = stb.tick && intvDue;
    stb.injNeg = offNeg;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !loopEn) begin
      phaseCnt <= '0;
      intvCnt  <= '0;
    end else if (stb.tick) begin
      phaseCnt <= '0;
      intvCnt  <= intvDue ? '0 : intvCnt + INTV_W'(1);
    end else begin
      phaseCnt <= phaseCnt + PH_W'(1);
    end
  end

  // R4: the interval count restarts after each injection
  assert_count_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.inject |=> (intvCnt == '0));

  // R8: a disabled loop keeps its counters at zero
  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !loopEn |=> (phaseCnt == '0) && (intvCnt == '0));

  // R5: a period closes with the phase wrapping to its first cycle
  assert_period_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.tick |=> (phaseCnt == '0) && !stb.tick);

endmodule

// File: rtl/loop_integ_datapath.sv
module loop_integ_datapath
  import loop_integ_pkg::*;
#(
  parameter int ACC_W   = 8,
  parameter int DET_W   = 4,
  parameter int WPU_W   = 4,
  parameter int UPD_CYC = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrl_stb_t               stb,
  input  logic                    detValid,
  input  logic signed [DET_W-1:0] detVal,
  input  logic [WPU_W-1:0]        unitWidth,
  output logic                    pulseActive,
  output logic                    pulseNeg,
  output logic signed [ACC_W-1:0] integOut
);

  localparam int SUM_W  = ACC_W + 2;
  localparam int PROD_W = ACC_W + WPU_W;
  localparam int CNT_W  = $clog2(UPD_CYC + 1);
  localparam int MAX_I  = 2 ** (ACC_W - 1) - 1;
  localparam int MIN_I  = -(2 ** (ACC_W - 1));
  localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'(MAX_I);
  localparam logic signed [SUM_W-1:0] SUM_MIN = SUM_W'(MIN_I);
  localparam logic signed [ACC_W-1:0] ACC_MAX = ACC_W'(MAX_I);
  localparam logic signed [ACC_W-1:0] ACC_MIN = ACC_W'(MIN_I);
  localparam logic [CNT_W-1:0]        LEN_CAP = CNT_W'(UPD_CYC);

  logic signed [ACC_W-1:0] integ;
  logic signed [ACC_W-1:0] snap;
  logic [CNT_W-1:0]        pulseLeft;
  logic                    pulseNegQ;

  logic signed [SUM_W-1:0] integExt, detExt, offExt, sumWide;
  logic signed [ACC_W-1:0] integNext;
  logic [ACC_W-1:0]        magNext;
  logic [PROD_W-1:0]       prod;
  logic [CNT_W-1:0]        lenNext;

  // Saturating accumulation of detector count and unit offset
  always_comb begin
    integExt = $signed({{(SUM_W - ACC_W){integ[ACC_W-1]}}, integ});
    detExt   = detValid ? $signed({{(SUM_W - DET_W){detVal[DET_W-1]}}, detVal}) : '0;
    offExt   = !stb.inject ? '0 : (stb.injNeg ? -SUM_W'(1) : SUM_W'(1));
    sumWide  = integExt + detExt + offExt;
    if (sumWide > SUM_MAX)      integNext = ACC_MAX;
    else if (sumWide < SUM_MIN) integNext = ACC_MIN;
    else                        integNext = sumWide[ACC_W-1:0];
  end

  // Pulse length: magnitude times width-per-unit, capped at one period
  always_comb begin
    magNext = integNext[ACC_W-1] ? $unsigned(~integNext + ACC_W'(1)) : $unsigned(integNext);
    prod    = PROD_W'(magNext) * PROD_W'(unitWidth);
    lenNext = (32'(prod) > 32'(UPD_CYC)) ? LEN_CAP : CNT_W'(prod);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      integ     <= '0;
      snap      <= '0;
      pulseLeft <= '0;
      pulseNegQ <= 1'b0;
    end else if (stb.clear) begin
      integ     <= '0;
      snap      <= '0;
      pulseLeft <= '0;
    end else begin
      integ <= integNext;
      if (stb.tick) begin
        snap      <= integNext;
        pulseLeft <= lenNext;
        if (integNext != '0) pulseNegQ <= integNext[ACC_W-1];
      end else if (pulseLeft != '0) begin
        pulseLeft <= pulseLeft - CNT_W'(1);
      end
    end
  end

  assign pulseActive = (pulseLeft != '0);
  assign pulseNeg    = pulseNegQ;
  assign integOut    = integ;

  // R3: at the upper rail only a negative push can move the integrator
  assert_sat_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clear && integ == ACC_MAX && !(detValid && detVal < 0) && !(stb.inject && stb.injNeg))
    |=> (integ == ACC_MAX));

  // R3: at the lower rail only a positive push can move the integrator
  assert_sat_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clear && integ == ACC_MIN && !(detValid && detVal > 0) && !(stb.inject && !stb.injNeg))
    |=> (integ == ACC_MIN));

  // R5: a pulse only starts right after a period boundary
  assert_pulse_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseActive) |-> $past(stb.tick));

  // R6: the remaining length never exceeds a period
  assert_width_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    pulseLeft <= LEN_CAP);

  // R7: an active pulse has a nonzero capture with matching polarity
  assert_sign_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    pulseActive |-> (snap != '0) && (pulseNeg == snap[ACC_W-1]));

  // R8: a disabled loop is silent and zeroed
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> !pulseActive && (integ == '0));

endmodule

// File: rtl/loop_integ_driver.sv
module loop_integ_driver
  import loop_integ_pkg::*;
#(
  parameter int ACC_W   = 8,
  parameter int DET_W   = 4,
  parameter int WPU_W   = 4,
  parameter int UPD_CYC = 16,
  parameter int INTV_W  = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    loopEn,
  input  logic                    detValid,
  input  logic signed [DET_W-1:0] detVal,
  input  logic                    offNeg,
  input  logic [INTV_W-1:0]       offInterval,
  input  logic [WPU_W-1:0]        unitWidth,
  output logic                    pulseActive,
  output logic                    pulseNeg,
  output logic signed [ACC_W-1:0] integOut
);

  ctrl_stb_t stb;

  loop_integ_ctrl #(
    .UPD_CYC(UPD_CYC),
    .INTV_W (INTV_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loopEn     (loopEn),
    .offNeg     (offNeg),
    .offInterval(offInterval),
    .stb        (stb)
  );

  loop_integ_datapath #(
    .ACC_W  (ACC_W),
    .DET_W  (DET_W),
    .WPU_W  (WPU_W),
    .UPD_CYC(UPD_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .detValid   (detValid),
    .detVal     (detVal),
    .unitWidth  (unitWidth),
    .pulseActive(pulseActive),
    .pulseNeg   (pulseNeg),
    .integOut   (integOut)
  );

endmodule

// File: tb/loop_integ_driver_bench.sv
`timescale 1ns/1ps
module loop_integ_driver_bench;

  localparam int P = 16;

  typedef struct packed {
    logic signed [3:0] det;
    logic              vld;
    logic signed [7:0] integ;  // expected integrator at period start
    logic [4:0]        width;  // expected pulse cycles in this period
    logic              neg;    // expected sign at period start
  } row_t;

  // Per period, unitWidth = 2, no offsets
  localparam row_t TBL [10] = '{
    '{ 4'sd3,  1'b1,  8'sd0,  5'd0,  1'b0},
    '{-4'sd5,  1'b1,  8'sd3,  5'd6,  1'b0},
    '{ 4'sd5,  1'b0, -8'sd2,  5'd4,  1'b1},
    '{ 4'sd7,  1'b1, -8'sd2,  5'd4,  1'b1},
    '{ 4'sd7,  1'b1,  8'sd5,  5'd10, 1'b0},
    '{-4'sd8,  1'b1,  8'sd12, 5'd16, 1'b0},
    '{-4'sd4,  1'b1,  8'sd4,  5'd8,  1'b0},
    '{-4'sd1,  1'b1,  8'sd0,  5'd0,  1'b0},
    '{ 4'sd1,  1'b1, -8'sd1,  5'd2,  1'b1},
    '{ 4'sd0,  1'b1,  8'sd0,  5'd0,  1'b1}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              loopEn = 1'b0;
  logic              detValid = 1'b0;
  logic signed [3:0] detVal = '0;
  logic              offNeg = 1'b0;
  logic [9:0]        offInterval = '0;
  logic [3:0]        unitWidth = '0;
  logic              pulseActive;
  logic              pulseNeg;
  logic signed [7:0] integOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  loop_integ_driver u_loop_integ_driver (
    .clk(clk), .rstN(rstN), .loopEn(loopEn), .detValid(detValid),
    .detVal(detVal), .offNeg(offNeg), .offInterval(offInterval),
    .unitWidth(unitWidth), .pulseActive(pulseActive), .pulseNeg(pulseNeg),
    .integOut(integOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge that is the first cycle of a period; returns at the
  // first negedge of the next period.
  task automatic runPeriod(input logic signed [3:0] det, input logic vld,
                           input bit every, input bit follow,
                           output int width, output int integStart, output int negStart);
    width = 0;
    for (int i = 0; i < P; i++) begin
      if (i == 0) begin
        integStart = int'(integOut);
        negStart   = int'(pulseNeg);
      end
      if (pulseActive) width++;
      if (follow) begin
        detValid = (i == 0) && pulseActive;
        detVal   = pulseNeg ? 4'sd1 : -4'sd1;
      end else begin
        detValid = vld && (every || i == 0);
        detVal   = det;
      end
      @(negedge clk);
    end
  endtask

  task automatic stopLoop();
    loopEn = 1'b0;
    detValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(100000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int w, ig, ng;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 integ", int'(integOut), 0);
    check("R1 pulse", int'(pulseActive), 0);
    check("R1 sign", int'(pulseNeg), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R2, R5, R6, R7
    unitWidth = 4'd2;
    loopEn = 1'b1;
    for (int r = 0; r < 10; r++) begin
      runPeriod(TBL[r].det, TBL[r].vld, 1'b0, 1'b0, w, ig, ng);
      check($sformatf("R2 integ row %0d", r), ig, int'(TBL[r].integ));
      check($sformatf("R6 width row %0d (R5 delay)", r), w, int'(TBL[r].width));
      check($sformatf("R7 sign row %0d", r), ng, int'(TBL[r].neg));
    end

    // R3: drive both rails
    stopLoop();
    unitWidth = 4'd1;
    loopEn = 1'b1;
    runPeriod(4'sd7, 1'b1, 1'b1, 1'b0, w, ig, ng);
    runPeriod(4'sd7, 1'b1, 1'b1, 1'b0, w, ig, ng);
    check("R2 integ after 16 counts", ig, 112);
    runPeriod(-4'sd8, 1'b1, 1'b1, 1'b0, w, ig, ng);
    check("R3 upper rail", ig, 127);
    check("R6 capped width", w, 16);
    runPeriod(-4'sd8, 1'b1, 1'b1, 1'b0, w, ig, ng);
    runPeriod(-4'sd8, 1'b1, 1'b1, 1'b0, w, ig, ng);
    runPeriod(4'sd0, 1'b0, 1'b0, 1'b0, w, ig, ng);
    check("R3 lower rail", ig, -128);
    check("R6 capped width negative", w, 16);
    check("R7 sign negative", ng, 1);

    // R8: disabled loop ignores detector
    stopLoop();
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        detValid = 1'b1;
        detVal = 4'sd5;
        @(negedge clk);
        if (integOut != 0 || pulseActive) bad++;
      end
      check("R8 disabled quiet", bad, 0);
      check("R8 sign held", int'(pulseNeg), 1);
      detValid = 1'b0;
    end

    // R4: positive offset every 4 periods, open loop
    stopLoop();
    offInterval = 10'd4;
    offNeg = 1'b0;
    unitWidth = 4'd1;
    loopEn = 1'b1;
    for (int k = 0; k < 9; k++) begin
      runPeriod(4'sd0, 1'b0, 1'b0, 1'b0, w, ig, ng);
      if (k == 3) check("R4 before first offset", ig, 0);
      if (k == 4) begin
        check("R4 first offset", ig, 1);
        check("R6 unit width", w, 1);
        check("R7 positive sign", ng, 0);
      end
      if (k == 8) check("R4 second offset", ig, 2);
    end

    // R4: negative offset every period
    stopLoop();
    offNeg = 1'b1;
    offInterval = 10'd1;
    loopEn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      runPeriod(4'sd0, 1'b0, 1'b0, 1'b0, w, ig, ng);
      if (k == 3) begin
        check("R4 negative offsets", ig, -3);
        check("R6 width 3", w, 3);
        check("R7 negative sign", ng, 1);
      end
    end

    // R4: interval of 256 periods
    stopLoop();
    offNeg = 1'b0;
    offInterval = 10'd256;
    unitWidth = 4'd0;
    loopEn = 1'b1;
    for (int k = 0; k < 257; k++) begin
      runPeriod(4'sd0, 1'b0, 1'b0, 1'b0, w, ig, ng);
      if (k == 255) check("R4 interval 256 before", ig, 0);
      if (k == 256) begin
        check("R4 interval 256 after", ig, 1);
        check("R6 zero width-per-unit", w, 0);
      end
    end

    // R9: closed loop cancels each injected offset
    stopLoop();
    offInterval = 10'd4;
    unitWidth = 4'd3;
    loopEn = 1'b1;
    for (int k = 0; k < 10; k++) begin
      runPeriod(4'sd0, 1'b0, 1'b0, 1'b1, w, ig, ng);
      if (k == 4) begin
        check("R9 offset present", ig, 1);
        check("R9 pulse width", w, 3);
      end
      if (k == 5) check("R9 back to zero", ig, 0);
      if (k == 8) check("R9 second offset", ig, 1);
      if (k == 9) check("R9 back to zero again", ig, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule